// File: doc/BRIEF.md
# Fourteen-Line Bus-Mapped GPIO Port

This block is a general-purpose I/O port with fourteen lines, attached to a small 8-bit register bus. Three registers sit at consecutive addresses. The lowest is a control register. The next holds lines 0 to 7 as one byte. The highest holds lines 8 to 13 in its six low bits. Lines are switched between input and output in groups of four, and each group has its own control bit. The two top lines can only be inputs.

Software writes the output latches and reads back a mix of values: the synchronized pin level for lines that are inputs, and the driven value for lines that are outputs. An enable bit in the control register routes the synchronized top line to an interrupt request output. A separate enable input makes line 8 an output that mirrors a status LED. The block drives per-line output data and per-line output enable, and the tristate buffers sit in the pad ring outside the block.

Top module: `gpio14_port`

## Requirements
- R1: After reset the control register reads 0x00, every output latch is 0, every `pin_oe` bit is 0 and `irq` is 0.
- R2: With the default base of 3, address 2 is the control register, address 3 holds lines 7:0 and bits 5:0 of address 4 hold lines 13:8. Reads of addresses 0, 1, 5, 6 and 7 return 0x00. Writes to those addresses change nothing.
- R3: Control bit 0 enables the outputs of lines 3:0, bit 1 those of lines 7:4 and bit 5 those of lines 11:8. A value of 1 means output.
- R4: `pin_oe[13:12]` is always 0, whatever the control register holds.
- R5: A data write always updates the output latches, also for lines that are inputs. `pin_out` carries the latch of every line except line 8 while the LED mirror is on.
- R6: A read of a data address returns the driven value for output lines and, for input lines, the pin level delayed by a two-flop synchronizer. Bits 7:6 of address 4 read 0.
- R7: Control bits 2, 3, 4 and 6 read back as written and have no effect on `pin_oe`, `pin_out` or `irq`.
- R8: `irq` equals synchronized line 13 when control bit 7 is 1, and it is 0 when control bit 7 is 0.
- R9: While `led_mirror_en` is 1, line 8 is an output whatever control bit 5 holds, and `pin_out[8]` and its read-back follow `led_on`.
- R10: While `cs` is 0, the write and read strobes have no effect: registers and `rd_data` keep their values.
- R11: `rd_data` is registered. It takes the addressed value on the clock edge that samples `cs` and `rd` high, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select for bus accesses |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 14 | Pad input levels |
| pin_out | output | 14 | Per-line output data |
| pin_oe | output | 14 | Per-line output enable |
| led_mirror_en | input | 1 | Forces line 8 to mirror the LED |
| led_on | input | 1 | LED state |
| irq | output | 1 | Interrupt request from line 13 |

## Verification
The case hardest to reach from the ports is the read-back of a line whose direction changes after its latch was written while it was an input. In that case the read result depends on two earlier writes and on a pin level that has passed through the synchronizer. The stimulus writes a latch pattern that differs from the pin pattern while the group is an input, checks that the read returns the pins, then flips the direction and checks that the latch appears. A random phase mixes writes to all eight addresses, pin and LED changes, and reads, always letting pins settle for three cycles so that the synchronized level is known. Directed cases cover the sync latency on the interrupt path and the LED override with control bit 5 cleared.

// File: rtl/gpio14_pkg.sv
package gpio14_pkg;

   // Control register bit positions; software depends on these.
   localparam int CTL_DIR_G0 = 0;
   localparam int CTL_DIR_G1 = 1;
   localparam int CTL_DIR_G2 = 5;
   localparam int CTL_IRQ_EN = 7;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_LO   = 2'd2,
      SEL_HI   = 2'd3
   } reg_sel_e;

   function automatic int group_ctl_bit(input int grp);
      case (grp)
         0:       return CTL_DIR_G0;
         1:       return CTL_DIR_G1;
         default: return CTL_DIR_G2;
      endcase
   endfunction

endpackage

// File: rtl/gpio14_sync.sv
module gpio14_sync #(
   parameter int WIDTH  = 14,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio14_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_q[s] <= '0;
         end else if (s == 0) begin
            stg_q[s] <= d_in;
         end else begin
            stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/gpio14_regs.sv
module gpio14_regs
   import gpio14_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 8,
   parameter int LINES   = 14,
   parameter int LO_ADDR = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LINES-1:0]  rd_lines,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [LINES-1:0]  out_q,
   output logic [DATA_W-1:0] rd_data
);

   localparam int HI_BITS   = LINES - DATA_W;
   localparam int CTRL_ADDR = LO_ADDR - 1;
   localparam int HI_ADDR   = LO_ADDR + 1;

   if (HI_BITS < 1 || HI_BITS > DATA_W) begin : g_bad_lines
      $error("gpio14_regs: LINES must lie in DATA_W+1 .. 2*DATA_W");
   end
   if (CTRL_ADDR < 0 || HI_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio14_regs: LO_ADDR leaves no room for its neighbours");
   end

   reg_sel_e sel;
   logic     wr_en;
   logic     rd_en;

   always_comb begin
      sel = SEL_NONE;
      if (int'(addr) == CTRL_ADDR)    sel = SEL_CTRL;
      else if (int'(addr) == LO_ADDR) sel = SEL_LO;
      else if (int'(addr) == HI_ADDR) sel = SEL_HI;
   end

   assign wr_en = cs && wr;
   assign rd_en = cs && rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         out_q  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_CTRL: ctrl_q                <= wr_data;
            SEL_LO:   out_q[DATA_W-1:0]     <= wr_data;
            SEL_HI:   out_q[LINES-1:DATA_W] <= wr_data[HI_BITS-1:0];
            default:  ;
         endcase
      end
   end

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      case (sel)
         SEL_CTRL: rd_mux = ctrl_q;
         SEL_LO:   rd_mux = rd_lines[DATA_W-1:0];
         SEL_HI:   rd_mux = DATA_W'(rd_lines[LINES-1:DATA_W]);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

   p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_CTRL) |=> ctrl_q == $past(wr_data));

   p_idle_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> ($stable(ctrl_q) && $stable(out_q) && $stable(rd_data)));

   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/gpio14_dir.sv
module gpio14_dir
   import gpio14_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LINES    = 14,
   parameter int GROUP    = 4,
   parameter int FIXED_IN = 2,
   parameter int LED_LINE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic [LINES-1:0]  out_q,
   input  logic [LINES-1:0]  pin_sync,
   input  logic              led_mirror_en,
   input  logic              led_on,
   output logic [LINES-1:0]  pin_out,
   output logic [LINES-1:0]  pin_oe,
   output logic [LINES-1:0]  rd_lines,
   output logic              irq
);

   localparam int DIR_LINES = LINES - FIXED_IN;
   localparam int N_GROUPS  = DIR_LINES / GROUP;
   localparam int IRQ_LINE  = LINES - 1;

   if (N_GROUPS * GROUP != DIR_LINES) begin : g_bad_groups
      $error("gpio14_dir: direction-controlled lines must fill whole groups");
   end
   if (LED_LINE >= DIR_LINES) begin : g_bad_led
      $error("gpio14_dir: LED line must be a direction-controlled line");
   end

   logic [N_GROUPS-1:0] grp_out;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      assign grp_out[g] = ctrl_q[group_ctl_bit(g)];
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (i >= DIR_LINES) begin : g_fixed_in
         assign pin_oe[i]  = 1'b0;
         assign pin_out[i] = out_q[i];
      end else if (i == LED_LINE) begin : g_led
         assign pin_oe[i]  = led_mirror_en | grp_out[i / GROUP];
         assign pin_out[i] = led_mirror_en ? led_on : out_q[i];
      end else begin : g_plain
         assign pin_oe[i]  = grp_out[i / GROUP];
         assign pin_out[i] = out_q[i];
      end
      assign rd_lines[i] = pin_oe[i] ? pin_out[i] : pin_sync[i];
   end

   assign irq = ctrl_q[CTL_IRQ_EN] & pin_sync[IRQ_LINE];

   // Control bits without a function are only stored.
   logic unused_ctrl;
   assign unused_ctrl = ^{ctrl_q[4:2], ctrl_q[6]};

   p_led_override_r9: assert property (@(posedge clk) disable iff (!rst_n)
      led_mirror_en |-> (pin_oe[LED_LINE] && rd_lines[LED_LINE] == led_on));

   p_input_readback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe == '0) |-> rd_lines == pin_sync);

endmodule

// File: rtl/gpio14_port.sv
module gpio14_port
   import gpio14_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 8,
   parameter int LINES       = 14,
   parameter int GROUP       = 4,
   parameter int FIXED_IN    = 2,
   parameter int LO_ADDR     = 3,
   parameter int LED_LINE    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [LINES-1:0]  pin_in,
   output logic [LINES-1:0]  pin_out,
   output logic [LINES-1:0]  pin_oe,
   input  logic              led_mirror_en,
   input  logic              led_on,
   output logic              irq
);

   localparam int DIR_LINES = LINES - FIXED_IN;
   localparam int G2_LO     = 2 * GROUP;

   if (DATA_W != 8) begin : g_bad_width
      $error("gpio14_port: control layout needs an 8-bit bus");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [LINES-1:0]  out_q;
   logic [LINES-1:0]  pin_sync;
   logic [LINES-1:0]  rd_lines;

   gpio14_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (pin_sync)
   );

   gpio14_regs #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .LINES   (LINES),
      .LO_ADDR (LO_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (cs),
      .rd       (rd),
      .wr       (wr),
      .addr     (addr),
      .wr_data  (wr_data),
      .rd_lines (rd_lines),
      .ctrl_q   (ctrl_q),
      .out_q    (out_q),
      .rd_data  (rd_data)
   );

   gpio14_dir #(
      .DATA_W   (DATA_W),
      .LINES    (LINES),
      .GROUP    (GROUP),
      .FIXED_IN (FIXED_IN),
      .LED_LINE (LED_LINE)
   ) u_dir (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctrl_q        (ctrl_q),
      .out_q         (out_q),
      .pin_sync      (pin_sync),
      .led_mirror_en (led_mirror_en),
      .led_on        (led_on),
      .pin_out       (pin_out),
      .pin_oe        (pin_oe),
      .rd_lines      (rd_lines),
      .irq           (irq)
   );

   p_fixed_inputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[LINES-1:DIR_LINES] == '0);

   p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CTL_IRQ_EN] |-> !irq);

   p_group2_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !led_mirror_en |-> pin_oe[G2_LO+GROUP-1:G2_LO] == {GROUP{ctrl_q[CTL_DIR_G2]}});

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q == '0 && !led_mirror_en) |-> (pin_oe == '0 && !irq));

endmodule

// File: tb/gpio14_port_bench.sv
module gpio14_port_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs, rd, wr;
   logic [2:0]  addr;
   logic [7:0]  wr_data;
   logic [7:0]  rd_data;
   logic [13:0] pin_in;
   logic [13:0] pin_out;
   logic [13:0] pin_oe;
   logic        led_mirror_en, led_on;
   logic        irq;

   int checks = 0;
   int errors = 0;

   logic [7:0]  m_ctrl;
   logic [13:0] m_out;

   always #5 clk = ~clk;

   gpio14_port u_gpio14_port (
      .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .led_mirror_en(led_mirror_en),
      .led_on(led_on), .irq(irq)
   );

   function automatic logic [13:0] f_oe();
      logic [13:0] o;
      o = {2'b00, {4{m_ctrl[5]}}, {4{m_ctrl[1]}}, {4{m_ctrl[0]}}};
      if (led_mirror_en) o[8] = 1'b1;
      return o;
   endfunction

   function automatic logic [13:0] f_drv();
      logic [13:0] d;
      d = m_out;
      if (led_mirror_en) d[8] = led_on;
      return d;
   endfunction

   function automatic logic [7:0] f_read(input logic [2:0] a);
      logic [13:0] l;
      l = (f_oe() & f_drv()) | (~f_oe() & pin_in);
      case (a)
         3'd2:    return m_ctrl;
         3'd3:    return l[7:0];
         3'd4:    return {2'b00, l[13:8]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_pins(input string req);
      chk(req, 32'(pin_oe), 32'(f_oe()));
      chk(req, 32'(pin_out), 32'(f_drv()));
      chk(req, 32'(irq), 32'(m_ctrl[7] & pin_in[13]));
   endtask

   task automatic bus(input logic c, input logic w, input logic r,
                      input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = c; wr = w; rd = r; addr = a; wr_data = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0; rd = 1'b0;
      if (c && w) begin
         case (a)
            3'd2: m_ctrl = d;
            3'd3: m_out[7:0] = d;
            3'd4: m_out[13:8] = d[5:0];
            default: ;
         endcase
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      bus(1'b1, 1'b1, 1'b0, a, d);
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a);
      logic [7:0] exp;
      exp = f_read(a);
      bus(1'b1, 1'b0, 1'b1, a, 8'h00);
      chk(req, 32'(rd_data), 32'(exp));
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] keep;
      void'($urandom(32'h1f2e3d4c));
      rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wr_data = '0;
      pin_in = '0; led_mirror_en = 1'b0; led_on = 1'b0;
      m_ctrl = '0; m_out = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", 32'(pin_oe), 0);
      chk("R1", 32'(pin_out), 0);
      chk("R1", 32'(irq), 0);
      rd_chk("R1", 3'd2);
      rd_chk("R1", 3'd4);

      // R4 fixed inputs even with every control bit set
      pin_in = 14'h3AC5; settle();
      wr_reg(3'd2, 8'hFF);
      chk("R4", 32'(pin_oe[13:12]), 0);
      check_pins("R3");
      rd_chk("R6", 3'd4);

      // R5 latch writes while inputs, then switch direction
      wr_reg(3'd2, 8'h00);
      wr_reg(3'd3, 8'hA5);
      wr_reg(3'd4, 8'hFF);
      chk("R5", 32'(pin_out), 32'h3FA5);
      rd_chk("R6", 3'd3);
      wr_reg(3'd2, 8'h01);
      rd_chk("R5", 3'd3);
      wr_reg(3'd2, 8'h23);
      rd_chk("R5", 3'd4);
      chk("R6", 32'(rd_data[7:6]), 0);

      // R7 unused control bits have no effect
      wr_reg(3'd2, 8'h5C);
      pin_in[13] = 1'b1; settle();
      chk("R7", 32'(pin_oe), 0);
      chk("R7", 32'(irq), 0);
      rd_chk("R7", 3'd2);

      // R8 irq gate and synchronizer latency (R6)
      wr_reg(3'd2, 8'h80);
      chk("R8", 32'(irq), 1);
      pin_in[13] = 1'b0;
      @(negedge clk);
      chk("R6", 32'(irq), 1);
      @(negedge clk);
      chk("R8", 32'(irq), 0);

      // R9 LED override with group bit clear
      wr_reg(3'd2, 8'h00);
      wr_reg(3'd4, 8'h00);
      led_mirror_en = 1'b1; led_on = 1'b1;
      @(negedge clk);
      check_pins("R9");
      rd_chk("R9", 3'd4);
      led_on = 1'b0;
      @(negedge clk);
      check_pins("R9");
      rd_chk("R9", 3'd4);
      led_mirror_en = 1'b0;

      // R2 unmapped addresses
      wr_reg(3'd0, 8'hFF); wr_reg(3'd1, 8'hFF); wr_reg(3'd5, 8'hFF);
      wr_reg(3'd6, 8'hFF); wr_reg(3'd7, 8'hFF);
      check_pins("R2");
      rd_chk("R2", 3'd2);
      rd_chk("R2", 3'd6);
      rd_chk("R2", 3'd0);

      // R10 and R11: strobes without chip select
      wr_reg(3'd2, 8'h21);
      rd_chk("R11", 3'd2);
      keep = rd_data;
      bus(1'b0, 1'b1, 1'b0, 3'd2, 8'hDE);
      bus(1'b0, 1'b0, 1'b1, 3'd3, 8'h00);
      chk("R10", 32'(rd_data), 32'(keep));
      check_pins("R10");
      rd_chk("R10", 3'd2);

      // Random mix
      for (int it = 0; it < 500; it++) begin
         int op;
         op = int'($urandom % 4);
         case (op)
            0: begin
               pin_in = 14'($urandom);
               led_mirror_en = 1'($urandom);
               led_on = 1'($urandom);
               settle();
               check_pins("R3");
            end
            1: wr_reg(3'($urandom), 8'($urandom));
            2: rd_chk("R6", 3'($urandom));
            default: check_pins("R5");
         endcase
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule